// File: doc/BRIEF.md
# Bidirectional GPIO Port with Software Pulldowns

This block is a parallel I/O port of configurable width (eight pins by default) that sits behind a simple memory-mapped register bus. Software sets each pin as an input or an output through a direction register, and writes output levels into a data register. Reading the data address returns, bit by bit, the stored level for output pins and the synchronized live pin level for input pins. Each pin also has a weak pulldown that an external pad model applies when the block asks for it.

A pulldown is requested only for a pin that is an input and whose bit in the pulldown inhibit register is clear. A build-time parameter stands in for a factory option. When that option is off, no pulldown is ever requested. Reset clears the direction and inhibit registers. The data register is left out of reset on purpose, so a value written before a reset is still there afterwards.

The bus has one register slot per address. Reads are combinational from the address. Writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high.

Top module: `gpio_pd_port`

## Requirements
- R1: Reset (rst_n low) clears the direction register (offset 0x04) and the pulldown inhibit register (offset 0x10), so both read back 0x00 and every pin_oe bit is 0.
- R2: Reset leaves the data register (offset 0x00) unchanged. A value written before a reset reads back after the reset once the pins are made outputs.
- R3: When a direction bit is 1, the pin is an output: its pin_oe bit is 1 and its pin_out bit equals the stored data bit. When a direction bit is 0, pin_oe and pin_out are both 0 for that pin.
- R4: A read at offset 0x00 returns the stored data bit for each output pin and the synchronized pin_in level for each input pin.
- R5: A write at offset 0x00 stores every bit, including bits for input pins. A stored bit for an input pin appears on pin_out only after its direction bit is set.
- R6: With PD_ALLOWED=1, pin_pd_en for a pin is 1 exactly when both its inhibit bit and its direction bit are 0. A direction bit of 1 forces pin_pd_en to 0 whatever the inhibit bit holds.
- R7: With PD_ALLOWED=0, every pin_pd_en bit stays 0 for all register contents.
- R8: The direction register (0x04) and the inhibit register (0x10) read back the last value written to them.
- R9: A read at any address other than 0x00, 0x04 or 0x10 returns 0x00. A write to such an address changes none of the three registers.
- R10: A change on pin_in shows up in the data read-back two clock edges later. After only one edge, the old level is still read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W (5) | Register byte offset |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_rdata | output | WIDTH (8) | Read data, combinational from bus_addr |
| pin_in | input | WIDTH (8) | Pad input levels, asynchronous |
| pin_out | output | WIDTH (8) | Pad output levels, 0 on input pins |
| pin_oe | output | WIDTH (8) | Pad output enables, one per pin |
| pin_pd_en | output | WIDTH (8) | Pad pulldown enables, one per pin |

## Verification
The hardest case to reach is data that survives a reset. Because the data register has no reset value, its starting content is unknown. After reset the direction register is also cleared, so a data read shows the pins rather than the stored bits. The stimulus therefore writes a known pattern and makes all pins outputs. It then pulses reset, checks that the direction and inhibit registers went to zero, and only then sets the pins back to outputs and reads the data register and pin_out.

The other tricky case is the two-edge input latency. The bench changes pin_in right after an edge and reads it back at three points: before the next edge, after one edge, and after two edges. The first two reads must show the old level.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;
    // Register offsets; software decodes these, so they are fixed.
    localparam int unsigned OFS_DATA = 32'h00;
    localparam int unsigned OFS_DIR  = 32'h04;
    localparam int unsigned OFS_INH  = 32'h10;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int AGE_W = $clog2(STAGES + 1) + 1;

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= chain_d[i];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

    // Edges seen since reset release, saturating; used only by the check below.
    logic [AGE_W-1:0] age_d, age_q;
    always_comb begin
        age_d = age_q;
        if (age_q < AGE_W'(STAGES)) age_d = age_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R10: read-back level lags the pad by exactly two edges
            a_r10_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= AGE_W'(2)) |-> (dout == $past(din, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pd_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  pins_sync,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  inh_q
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_INH  = ADDR_W'(OFS_INH);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] inh;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_en;

    always_comb begin
        regs_d = regs_q;
        wr_en  = bus_sel && bus_wr;
        if (wr_en) begin
            case (bus_addr)
                A_DATA:  regs_d.data = bus_wdata;
                A_DIR:   regs_d.dir  = bus_wdata;
                A_INH:   regs_d.inh  = bus_wdata;
                default: ;
            endcase
        end
    end

    // Only direction and inhibit take a reset value; data keeps its content.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.dir <= '0;
            regs_q.inh <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = (regs_q.data & regs_q.dir) | (pins_sync & ~regs_q.dir);
            A_DIR:   bus_rdata = regs_q.dir;
            A_INH:   bus_rdata = regs_q.inh;
            default: bus_rdata = '0;
        endcase
    end

    assign data_q = regs_q.data;
    assign dir_q  = regs_q.dir;
    assign inh_q  = regs_q.inh;

    // R1: a reset cycle leaves direction and inhibit cleared
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (regs_q.dir == '0) && (regs_q.inh == '0));

    // R5: a data write stores every bit regardless of direction
    a_r5_data_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_DATA) |=> (regs_q.data == $past(bus_wdata)));

    // R8: direction write lands unchanged
    a_r8_dir_written: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_DIR) |=> (regs_q.dir == $past(bus_wdata)));

    // R9: writes outside the map touch nothing
    a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr != A_DATA && bus_addr != A_DIR && bus_addr != A_INH)
        |=> ($stable(regs_q.data) && $stable(regs_q.dir) && $stable(regs_q.inh)));
endmodule

// File: rtl/gpio_pd_gate.sv
module gpio_pd_gate #(
    parameter int WIDTH      = 8,
    parameter bit PD_ALLOWED = 1'b1
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] inh,
    output logic [WIDTH-1:0] pd_en
);
    generate
        if (PD_ALLOWED) begin : g_pd_soft
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign pd_en[i] = !dir[i] && !inh[i];
            end
        end else begin : g_pd_none
            assign pd_en = '0;
        end
    endgenerate
endmodule

// File: rtl/gpio_pd_port.sv
module gpio_pd_port
    import gpio_pd_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2,
    parameter bit PD_ALLOWED  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_pd_en
);
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFS_DIR);

    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] data_q, dir_q, inh_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pins_sync)
    );

    gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pins_sync (pins_sync),
        .bus_rdata (bus_rdata),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .inh_q     (inh_q)
    );

    gpio_pd_gate #(.WIDTH(WIDTH), .PD_ALLOWED(PD_ALLOWED)) u_pd (
        .dir   (dir_q),
        .inh   (inh_q),
        .pd_en (pin_pd_en)
    );

    assign pin_oe  = dir_q;
    assign pin_out = data_q & dir_q;

    // R3: enables follow a direction write on the next cycle
    a_r3_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_DIR) |=> (pin_oe == $past(bus_wdata)));

    // R6: a pin that drives never has its pulldown on
    a_r6_no_pd_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pd_en & pin_oe) == '0);
endmodule

// File: tb/tb_gpio_pd_port.sv
module tb_gpio_pd_port;
    localparam int W = 8;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] rdata, pout, poe, ppd;
    logic [W-1:0] rdata2, pout2, poe2, ppd2;

    always #5 clk = ~clk;

    gpio_pd_port #(.WIDTH(W), .ADDR_W(AW), .PD_ALLOWED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pin_in),
        .pin_out(pout), .pin_oe(poe), .pin_pd_en(ppd));

    gpio_pd_port #(.WIDTH(W), .ADDR_W(AW), .PD_ALLOWED(1'b0)) dut_nopd (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata2), .pin_in(pin_in),
        .pin_out(pout2), .pin_oe(poe2), .pin_pd_en(ppd2));

    localparam int K_RDATA = 0, K_OUT = 1, K_OE = 2, K_PD = 3, K_PD_NONE = 4;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    logic [W-1:0] act;

    // Monitor: compare every queued expectation against the outputs
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            case (it.kind)
                K_RDATA: act = rdata;
                K_OUT:   act = pout;
                K_OE:    act = poe;
                K_PD:    act = ppd;
                default: act = ppd2;
            endcase
            compared++;
            if (act !== it.exp) begin
                mismatched++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        step();
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic expect_out(input int kind, input logic [W-1:0] e, input string req);
        item_t it;
        it.kind = kind; it.exp = e; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [W-1:0] e, input string req);
        sel = 1'b1; wr = 1'b0; addr = a;
        expect_out(K_RDATA, e, req);
        step();
        sel = 1'b0;
    endtask

    task automatic pulse_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        pulse_reset();

        // R1 reset values
        bus_read(5'h04, 8'h00, "R1 dir after reset");
        bus_read(5'h10, 8'h00, "R1 inh after reset");
        expect_out(K_OE, 8'h00, "R1 oe after reset");
        expect_out(K_OUT, 8'h00, "R3 out low on inputs");
        // R6 / R7 pulldowns with everything an input and nothing inhibited
        expect_out(K_PD, 8'hFF, "R6 all pulldowns on");
        expect_out(K_PD_NONE, 8'h00, "R7 option off");
        step();

        // R5: data written while inputs stays off the pins
        bus_write(5'h00, 8'hA5);
        expect_out(K_OUT, 8'h00, "R5 input data held back");
        expect_out(K_OE, 8'h00, "R5 oe still off");
        step();
        bus_write(5'h04, 8'hFF);
        expect_out(K_OUT, 8'hA5, "R5 stored data appears");
        expect_out(K_OE, 8'hFF, "R3 all outputs");
        expect_out(K_PD, 8'h00, "R6 outputs no pulldown");
        step();

        // R4 mixed read-back
        pin_in = 8'h3C;
        repeat (3) step();
        bus_write(5'h04, 8'h0F);
        bus_read(5'h00, 8'h35, "R4 mixed read");
        expect_out(K_OUT, 8'h05, "R3 partial outputs");
        step();

        // R10 latency with all pins inputs
        bus_write(5'h04, 8'h00);
        bus_read(5'h00, 8'h3C, "R4 all inputs");
        pin_in = 8'h99;
        bus_read(5'h00, 8'h3C, "R10 zero edges");
        bus_read(5'h00, 8'h3C, "R10 one edge");
        bus_read(5'h00, 8'h99, "R10 two edges");

        // R8 read-back
        bus_write(5'h10, 8'h5A);
        bus_read(5'h10, 8'h5A, "R8 inh readback");
        bus_write(5'h04, 8'hC3);
        bus_read(5'h04, 8'hC3, "R8 dir readback");
        // R6 gating by inhibit and direction
        expect_out(K_PD, 8'h24, "R6 mixed gating");
        expect_out(K_PD_NONE, 8'h00, "R7 option off mixed");
        step();

        // R9 unmapped accesses
        bus_write(5'h08, 8'hFF);
        bus_write(5'h1F, 8'hFF);
        bus_write(5'h01, 8'hFF);
        bus_read(5'h04, 8'hC3, "R9 dir untouched");
        bus_read(5'h10, 8'h5A, "R9 inh untouched");
        bus_read(5'h08, 8'h00, "R9 unmapped read 08");
        bus_read(5'h01, 8'h00, "R9 unmapped read 01");
        bus_write(5'h04, 8'hFF);
        bus_read(5'h00, 8'hA5, "R9 data untouched");

        // R2 data survives reset
        bus_write(5'h00, 8'h6E);
        pulse_reset();
        bus_read(5'h04, 8'h00, "R1 dir after second reset");
        bus_read(5'h10, 8'h00, "R1 inh after second reset");
        bus_write(5'h04, 8'hFF);
        bus_read(5'h00, 8'h6E, "R2 data kept");
        expect_out(K_OUT, 8'h6E, "R2 pins show kept data");
        step();

        step();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule